// File: doc/BRIEF.md
# Oversampled Edge-Tracking Clock Recovery

This block recovers a bit clock from a serial stream using a local clock that runs much faster than the data. In NRZI mode a bit cell is nominally 32 local clocks long; in FM mode it is 16. A cell counter marks out cells. Each transition on the synchronized data input is classified by the count at which it is seen. The counter then stretches or shrinks the next cell by one count, so that over time data transitions land on count 0 and the recovered clock's rising edge sits at the middle of each bit.

A second counter divides the local clock by the cell length of the selected mode and never takes a correction. It gives a steady transmit clock. The mode select is meant to change only while the block is disabled.

Top module: `edge_track_dpll`

## Requirements
- R1: While reset is asserted, both `rxClk` and `txClk` are low.
- R2: While `enable` is low, both outputs stay low and transitions on `rxData` have no effect. After `enable` rises, the first cell has its nominal length.
- R3: When enabled, `txClk` has a period of exactly 32 clocks in NRZI mode (`modeFm`=0) and 16 in FM mode (`modeFm`=1). It is high for the second half of each period, and data transitions never change it.
- R4: With no data transitions, `rxClk` has a period equal to the nominal cell length (32 or 16). It rises when the cell count reaches half the cell length and stays high for half a cell.
- R5: A transition seen at a count from 1 to half the cell length minus 1 leaves the current cell unchanged and makes the following cell one count longer.
- R6: A transition seen at a count from half the cell length to the last count makes the following cell one count shorter.
- R7: A transition seen at count 0 causes no correction.
- R8: In FM mode, transitions seen at counts from a quarter up to (not including) three quarters of the cell (counts 4 to 11) are ignored.
- R9: Rising and falling transitions on `rxData` are treated alike.
- R10: An input change is sampled at clock edge k and is taken as seen at the count held during the cycle that starts at edge k+1. With NRZI data whose bit period is 33 (or 31) clocks on one bit in eight, and after acquisition, every data change captured at edge k is followed by a rising `rxClk` at edge k+1+16 give or take 2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 32x (NRZI) or 16x (FM) the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs both counters when high; holds them cleared when low |
| modeFm | input | 1 | 0 selects NRZI (32-count cell), 1 selects FM (16-count cell) |
| rxData | input | 1 | Asynchronous serial data input |
| rxClk | output | 1 | Recovered receive clock, rising at mid-cell |
| txClk | output | 1 | Fixed-divide transmit clock with no phase correction |

## Verification
A wrong correction state shows at the ports as an `rxClk` interval that is off by one count. This appears in the cell after the offending transition, never in the one where it was seen, so the bench measures three successive intervals after a transition placed at a known count. A wrong cell counter or divider shows as a wrong period or high time within a single cell. A wrong sign on the correction shows up more slowly: over a few dozen bits of offset-rate data, the delay from a data change to the next `rxClk` rise drifts out of its window.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  // Pending phase correction for the next bit cell.
  typedef enum logic [1:0] {
    CORR_NONE  = 2'd0,
    CORR_LONG  = 2'd1,
    CORR_SHORT = 2'd2
  } corr_e;

  // Position flags from the datapath to the control.
  typedef struct packed {
    logic edgeSeen;
    logic lastCount;
    logic atOrigin;
    logic firstHalf;
    logic midWindow;
  } cellStatus_t;

  // Strobes from the control to the datapath, honoured on the last count.
  typedef struct packed {
    logic stretch;
    logic shrink;
  } corrStrobe_t;

endpackage

// File: rtl/dpll_datapath.sv
module dpll_datapath
  import dpll_pkg::*;
#(
  parameter int unsigned NRZI_LEN    = 32,
  parameter int unsigned FM_LEN      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        modeFm,
  input  logic        rxData,
  input  corrStrobe_t strobe,
  output cellStatus_t status,
  output logic        rxClk,
  output logic        txClk
);

  localparam int unsigned MAX_LEN = (NRZI_LEN > FM_LEN) ? NRZI_LEN : FM_LEN;
  localparam int          CNT_W   = $clog2(MAX_LEN + 2);

  // Input synchronizer chain
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic                   prevSample;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= rxData;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= 1'b0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSample <= 1'b0;
    else       prevSample <= syncOut;
  end

  // Mode-dependent cell geometry
  logic [CNT_W-1:0] nomLast;
  logic [CNT_W-1:0] halfPt;
  logic [CNT_W-1:0] quarterPt;
  logic [CNT_W-1:0] threeQPt;

  always_comb begin
    if (modeFm) begin
      nomLast   = CNT_W'(FM_LEN - 1);
      halfPt    = CNT_W'(FM_LEN / 2);
      quarterPt = CNT_W'(FM_LEN / 4);
      threeQPt  = CNT_W'((3 * FM_LEN) / 4);
    end else begin
      nomLast   = CNT_W'(NRZI_LEN - 1);
      halfPt    = CNT_W'(NRZI_LEN / 2);
      quarterPt = CNT_W'(NRZI_LEN / 4);
      threeQPt  = CNT_W'((3 * NRZI_LEN) / 4);
    end
  end

  // Bit-cell counter with a correctable terminal count
  logic [CNT_W-1:0] cellCnt;
  logic [CNT_W-1:0] termLast;
  logic [CNT_W-1:0] cellNext;
  logic             lastCount;

  assign lastCount = (cellCnt >= termLast);
  assign cellNext  = cellCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt  <= '0;
      termLast <= CNT_W'(NRZI_LEN - 1);
      rxClk    <= 1'b0;
    end else if (!enable) begin
      cellCnt  <= '0;
      termLast <= nomLast;
      rxClk    <= 1'b0;
    end else if (lastCount) begin
      cellCnt <= '0;
      rxClk   <= 1'b0;
      case ({strobe.stretch, strobe.shrink})
        2'b10:   termLast <= nomLast + 1'b1;
        2'b01:   termLast <= nomLast - 1'b1;
        default: termLast <= nomLast;
      endcase
    end else begin
      cellCnt <= cellNext;
      rxClk   <= (cellNext >= halfPt);
    end
  end

  // Fixed divider for the transmit clock
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] txNext;

  assign txNext = txCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txCnt <= '0;
      txClk <= 1'b0;
    end else if (!enable) begin
      txCnt <= '0;
      txClk <= 1'b0;
    end else if (txCnt >= nomLast) begin
      txCnt <= '0;
      txClk <= 1'b0;
    end else begin
      txCnt <= txNext;
      txClk <= (txNext >= halfPt);
    end
  end

  // Position flags for the control
  always_comb begin
    status.edgeSeen  = enable & (syncOut ^ prevSample);
    status.lastCount = lastCount;
    status.atOrigin  = (cellCnt == '0);
    status.firstHalf = (cellCnt < halfPt);
    status.midWindow = (cellCnt >= quarterPt) && (cellCnt < threeQPt);
  end

  // Assertions
  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!rxClk && !txClk && cellCnt == '0));

  assert_tx_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txCnt < nomLast) |=> (!enable || txCnt == $past(txCnt) + 1'b1));

  assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rstN)
    cellCnt <= termLast);

  assert_rise_at_half_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxClk) && $stable(modeFm)) |-> (cellCnt == halfPt));

  assert_stretch_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && lastCount && strobe.stretch) |=> (termLast == $past(nomLast) + 1'b1));

  assert_shrink_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enable && lastCount && strobe.shrink) |=> (termLast == $past(nomLast) - 1'b1));

endmodule

// File: rtl/dpll_control.sv
module dpll_control
  import dpll_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        modeFm,
  input  cellStatus_t status,
  output corrStrobe_t strobe
);

  corr_e pending;
  corr_e fresh;
  corr_e chosen;
  logic  accepted;

  // Classify a transition by the count at which it is seen
  always_comb begin
    accepted = status.edgeSeen && !(modeFm && status.midWindow);
    if (status.atOrigin)       fresh = CORR_NONE;
    else if (status.firstHalf) fresh = CORR_LONG;
    else                       fresh = CORR_SHORT;
    chosen = accepted ? fresh : pending;
  end

  always_comb begin
    strobe.stretch = status.lastCount && (chosen == CORR_LONG);
    strobe.shrink  = status.lastCount && (chosen == CORR_SHORT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pending <= CORR_NONE;
    else if (!enable)          pending <= CORR_NONE;
    else if (status.lastCount) pending <= CORR_NONE;
    else if (accepted)         pending <= fresh;
  end

  // Assertions
  assert_wrap_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && status.lastCount) |=> (pending == CORR_NONE));

  assert_origin_neutral_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && status.edgeSeen && status.atOrigin && !status.lastCount) |=> (pending == CORR_NONE));

  assert_mid_window_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && modeFm && status.edgeSeen && status.midWindow && !status.lastCount)
      |=> (pending == $past(pending)));

endmodule

// File: rtl/edge_track_dpll.sv
module edge_track_dpll
  import dpll_pkg::*;
#(
  parameter int unsigned NRZI_LEN    = 32,
  parameter int unsigned FM_LEN      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic modeFm,
  input  logic rxData,
  output logic rxClk,
  output logic txClk
);

  cellStatus_t cellStatus;
  corrStrobe_t corrStrobe;

  dpll_datapath #(
    .NRZI_LEN    (NRZI_LEN),
    .FM_LEN      (FM_LEN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .modeFm (modeFm),
    .rxData (rxData),
    .strobe (corrStrobe),
    .status (cellStatus),
    .rxClk  (rxClk),
    .txClk  (txClk)
  );

  dpll_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .modeFm (modeFm),
    .status (cellStatus),
    .strobe (corrStrobe)
  );

endmodule

// File: tb/tb_edge_track_dpll.sv
`timescale 1ns/1ps
module tb_edge_track_dpll;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic modeFm = 1'b0;
  logic rxData = 1'b0;
  logic rxClk;
  logic txClk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_track_dpll dut (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .modeFm (modeFm),
    .rxData (rxData),
    .rxClk  (rxClk),
    .txClk  (txClk)
  );

  function automatic int cellLen(input bit fm);
    return fm ? 16 : 32;
  endfunction

  // Delay in clocks from a data change to the next rxClk rise when locked
  function automatic int lockDelay(input bit fm);
    return cellLen(fm) / 2 + 2;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkRange(input string tag, input int got, input int lo, input int hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", tag, got, lo, hi);
    end
  endtask

  function automatic logic pick(input bit useTx);
    return useTx ? txClk : rxClk;
  endfunction

  // Count falling clock edges until the chosen output is seen rising
  task automatic waitRise(input bit useTx, output int n);
    logic was;
    bit   seen;
    was  = pick(useTx);
    n    = 0;
    seen = 1'b0;
    while (!seen && n < 400) begin
      @(negedge clk);
      n++;
      if (pick(useTx) && !was) seen = 1'b1;
      was = pick(useTx);
    end
  endtask

  // Right after a rise, count falling edges until the output is low
  task automatic waitFall(input bit useTx, output int n);
    n = 0;
    while (pick(useTx) && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic periodAndHigh(input bit useTx, input string tag, input int len);
    int n;
    waitRise(useTx, n);
    waitRise(useTx, n);
    check({tag, " period"}, n, len);
    waitFall(useTx, n);
    check({tag, " high"}, n, len / 2);
  endtask

  // Place a data change so it is seen at a known count, then measure three rise intervals
  task automatic edgeProbe(input string tag, input int d, input int e1, input int e2, input int e3);
    int n;
    waitRise(1'b0, n);
    repeat (d - 1) @(negedge clk);
    rxData = ~rxData;
    waitRise(1'b0, n);
    check({tag, " interval1"}, d - 1 + n, e1);
    waitRise(1'b0, n);
    check({tag, " interval2"}, n, e2);
    waitRise(1'b0, n);
    check({tag, " interval3"}, n, e3);
  endtask

  task automatic restart(input bit fm);
    @(negedge clk);
    enable = 1'b0;
    modeFm = fm;
    repeat (6) @(negedge clk);
    enable = 1'b1;
  endtask

  // NRZI stream with one long or short bit in eight; checks lock after settling (R10, R9)
  task automatic lockRun(input int skew, input int bits, input int settle);
    int   quiet;
    int   since;
    bit   armed;
    logic was;
    quiet = 0;
    since = 0;
    armed = 1'b0;
    was   = rxClk;
    for (int b = 0; b < bits; b++) begin
      int period;
      period = (b % 8 == 7) ? 32 + skew : 32;
      if ($urandom_range(0, 1) == 1 || quiet >= 2) begin
        rxData = ~rxData;
        armed  = 1'b1;
        since  = 0;
        quiet  = 0;
      end else begin
        quiet++;
      end
      for (int i = 0; i < period; i++) begin
        @(negedge clk);
        since++;
        if (armed && rxClk && !was) begin
          if (b >= settle)
            checkRange("R10 lock delay", since, lockDelay(1'b0) - 2, lockDelay(1'b0) + 2);
          armed = 1'b0;
        end
        was = rxClk;
      end
    end
  endtask

  initial begin
    int bad;
    void'($urandom(32'h5EED_0017));

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 rxClk in reset", rxClk, 0);
    check("R1 txClk in reset", txClk, 0);

    // R2: disabled, data toggling
    rstN = 1'b1;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i % 5 == 0) rxData = ~rxData;
      if (rxClk || txClk) bad++;
    end
    rxData = 1'b0;
    check("R2 outputs low while disabled", bad, 0);

    // NRZI nominal behaviour
    restart(1'b0);
    periodAndHigh(1'b1, "R3 nrzi txClk", 32);
    periodAndHigh(1'b0, "R4 nrzi rxClk", 32);

    // R5 + R9 (rising change seen at count 4), R6 + R9 (falling change at count 20), R7
    edgeProbe("R5 R9 nrzi early edge", 19, 32, 32, 33);
    edgeProbe("R6 R9 nrzi late edge", 3, 32, 31, 32);
    edgeProbe("R7 nrzi origin edge", 15, 32, 32, 32);
    periodAndHigh(1'b1, "R3 nrzi txClk after edges", 32);

    // R2: first cell nominal after re-enable
    restart(1'b0);
    begin
      int n;
      waitRise(1'b0, n);
      check("R2 first rise after enable", n, 16);
    end

    // FM mode
    restart(1'b1);
    periodAndHigh(1'b1, "R3 fm txClk", 16);
    periodAndHigh(1'b0, "R4 fm rxClk", 16);
    edgeProbe("R8 fm mid-window edge", 15, 16, 16, 16);
    edgeProbe("R5 fm early edge", 9, 16, 16, 17);
    edgeProbe("R6 fm late edge", 3, 16, 15, 16);
    periodAndHigh(1'b1, "R3 fm txClk after edges", 16);

    // R2: disable drops outputs
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 rxClk after disable", rxClk, 0);
    check("R2 txClk after disable", txClk, 0);

    // R10: lock with slow and fast data
    restart(1'b0);
    lockRun(1, 230, 80);
    restart(1'b0);
    lockRun(-1, 230, 80);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule